// File: doc/BRIEF.md
# Receive-Path DC-Blocking High-Pass Filter

This block sits behind a 12-bit sampling converter and removes the DC component from the sample stream. Each sample arrives as a signed two's-complement word with a valid strobe. A first-order recursive high-pass filter with its corner near 1/400 of the sample rate processes it. The filter can be switched out. The result is then clamped to the 12-bit range and presented in the chosen number format and precision, with its own valid strobe.

A small mode controller tracks the filter's condition in three states. `S_BYPASS` means the filter is out of the path and its history is held at zero. `S_ARMED` means the filter is in the path with no history yet. `S_TRACK` means the filter holds the history of at least one sample. Transitions: `GO_ARM` (S_BYPASS to S_ARMED, bypass released), `FIRST_SAMPLE` (S_ARMED to S_TRACK, a valid sample is taken), and `DROP` (any state to S_BYPASS, bypass asserted). Reset enters S_BYPASS.

Top module: `dcb_filter_top`

## Requirements
- R1: While `rst` is high, `out_vld` is 0. The filter history, the filtered output register and the mode state are cleared by the clock edge at which `rst` is high.
- R2: With `bypass` high, `out_vld` equals `in_vld` and the output is computed from `in_smp` in the same cycle, with no register on the path.
- R3: With the filter active, each valid sample updates the state as y = (x - x_prev)·64 + y - floor(y/64). Here y carries 6 fractional bits and x_prev is the previous valid sample. The integer output is floor(y/64). Invalid cycles leave the history unchanged.
- R4: With the filter active, `out_vld` is high exactly in the cycle after a cycle with `in_vld` high, and the data shown then belongs to that sample.
- R5: A filtered result above 2047 is shown as 2047 (0x7FF), and one below -2048 is shown as -2048 (0x800). It never wraps.
- R6: With `fmt_offset` high, the output word is the two's-complement word with only its top bit inverted. So midscale 0 is shown as 0x800 in full precision and 0x10 in half precision.
- R7: With `half_prec` high, `out_smp[4:0]` carries bits 11..7 of the clamped 12-bit result (truncated) and `out_smp[11:5]` is 0.
- R8: Any cycle with `bypass` high clears the filter history. The first filtered sample after bypass is released is therefore passed with x_prev = 0 and y = 0, so it is output equal to itself.
- R9: A constant input held with the filter active settles to an output of exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample valid |
| in_smp | input | 12 | Input sample, two's complement |
| bypass | input | 1 | 1 = filter out of path, zero latency |
| fmt_offset | input | 1 | 1 = offset binary output, 0 = two's complement |
| half_prec | input | 1 | 1 = 5-bit output in bits 4..0 |
| out_vld | output | 1 | Output sample valid |
| out_smp | output | 12 | Processed sample |

## Verification
A wrong filter history shows directly at the output. A stale or corrupted previous sample or accumulator changes the very next filtered word, one cycle after the next valid input. A leak term of the wrong size shows as a decay that differs from the expected one within a few samples of any step, and as a nonzero settled value under a constant input. A history that survives bypass shows in the first filtered word after bypass is released. A mistracked valid pipeline shows as a strobe one cycle early or late at the first filtered sample.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
    typedef enum logic [1:0] {
        S_BYPASS = 2'd0,
        S_ARMED  = 2'd1,
        S_TRACK  = 2'd2
    } dcb_state_e;
endpackage

// File: rtl/dcb_mode_fsm.sv
module dcb_mode_fsm
    import dcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byp,
    input  logic       in_vld,
    output logic       clr,
    output logic       sel_filt,
    output dcb_state_e state_o
);
    dcb_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= S_BYPASS;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_BYPASS: nxt = byp ? S_BYPASS : S_ARMED;            // GO_ARM
            S_ARMED:  begin
                if (byp)         nxt = S_BYPASS;                 // DROP
                else if (in_vld) nxt = S_TRACK;                  // FIRST_SAMPLE
                else             nxt = S_ARMED;
            end
            S_TRACK:  nxt = byp ? S_BYPASS : S_TRACK;            // DROP
            default:  nxt = S_BYPASS;
        endcase
    end

    always_comb begin
        clr      = byp;
        sel_filt = !byp;
        state_o  = state;
    end
endmodule

// File: rtl/dcb_hpf_core.sv
module dcb_hpf_core #(
    parameter int W = 12,
    parameter int G = 4,
    parameter int F = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_smp,
    output logic                out_vld,
    output logic signed [W+G-1:0] out_int
);
    localparam int SW = W + G + F;

    logic signed [W-1:0]  xp;
    logic signed [SW-1:0] y, y_nx, dext, step, leak, whole;
    logic signed [W:0]    diff;
    logic                 v;

    always_comb begin
        diff  = {in_smp[W-1], in_smp} - {xp[W-1], xp};
        dext  = SW'(diff);
        step  = dext <<< F;
        leak  = y >>> F;
        y_nx  = step + y - leak;
        whole = y >>> F;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            xp <= '0;
            y  <= '0;
            v  <= 1'b0;
        end else begin
            v <= in_vld;
            if (in_vld) begin
                xp <= in_smp;
                y  <= y_nx;
            end
        end
    end

    assign out_vld = v;
    assign out_int = whole[W+G-1:0];
endmodule

// File: rtl/dcb_out_fmt.sv
module dcb_out_fmt #(
    parameter int W  = 12,
    parameter int IW = 16,
    parameter int HB = 5
) (
    input  logic signed [IW-1:0] val,
    input  logic                 ob,
    input  logic                 half,
    output logic [W-1:0]         word
);
    localparam logic signed [IW-1:0] MAXV = IW'((1 << (W-1)) - 1);
    localparam logic signed [IW-1:0] MINV = -MAXV - IW'(1);

    logic [W-1:0]  sat;
    logic [HB-1:0] top;

    always_comb begin
        if (val > MAXV)      sat = MAXV[W-1:0];
        else if (val < MINV) sat = MINV[W-1:0];
        else                 sat = val[W-1:0];
    end

    generate
        if (HB < W) begin : g_half
            always_comb begin
                top = sat[W-1 -: HB] ^ {ob, {(HB-1){1'b0}}};
                if (half) word = {{(W-HB){1'b0}}, top};
                else      word = sat ^ {ob, {(W-1){1'b0}}};
            end
        end else begin : g_full
            always_comb begin
                top  = '0;
                word = sat ^ {ob, {(W-1){1'b0}}};
            end
        end
    endgenerate
endmodule

// File: rtl/dcb_filter_top.sv
module dcb_filter_top
    import dcb_pkg::*;
#(
    parameter int W  = 12,
    parameter int G  = 4,
    parameter int F  = 6,
    parameter int HB = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_smp,
    input  logic         bypass,
    input  logic         fmt_offset,
    input  logic         half_prec,
    output logic         out_vld,
    output logic [W-1:0] out_smp
);
    localparam int IW = W + G;

    logic                 clr, sel_filt, core_vld;
    logic signed [IW-1:0] core_int, src;
    dcb_state_e           state;

    dcb_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .byp(bypass), .in_vld(in_vld),
        .clr(clr), .sel_filt(sel_filt), .state_o(state)
    );

    dcb_hpf_core #(.W(W), .G(G), .F(F)) u_core (
        .clk(clk), .rst(rst), .clr(clr), .in_vld(in_vld),
        .in_smp(in_smp), .out_vld(core_vld), .out_int(core_int)
    );

    always_comb begin
        if (sel_filt) src = core_int;
        else          src = IW'($signed(in_smp));
        out_vld = !rst && (sel_filt ? core_vld : in_vld);
    end

    dcb_out_fmt #(.W(W), .IW(IW), .HB(HB)) u_fmt (
        .val(src), .ob(fmt_offset), .half(half_prec), .word(out_smp)
    );
endmodule

// File: rtl/dcb_filter_chk.sv
module dcb_filter_chk
    import dcb_pkg::*;
#(
    parameter int W  = 12,
    parameter int HB = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         in_vld,
    input logic [W-1:0] in_smp,
    input logic         bypass,
    input logic         fmt_offset,
    input logic         half_prec,
    input logic         out_vld,
    input logic [W-1:0] out_smp,
    input dcb_state_e   state
);
    // R1
    always_ff @(posedge clk) begin
        if (rst) rst_quiet_chk: assert (!out_vld);
    end

    // R2
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (bypass && !fmt_offset && !half_prec) |-> (out_vld == in_vld && out_smp == in_smp));

    // R6
    bypass_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (bypass && fmt_offset && !half_prec) |-> (out_smp == {~in_smp[W-1], in_smp[W-2:0]}));

    // R4
    filt_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass && in_vld) |=> (bypass || out_vld));

    // R4
    filt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !in_vld) |=> (bypass || !out_vld));

    // R7
    half_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        half_prec |-> (out_smp[W-1:HB] == '0));

    // R8
    bypass_state_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (state == S_BYPASS));
endmodule

bind dcb_filter_top dcb_filter_chk #(.W(W), .HB(HB)) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
    .bypass(bypass), .fmt_offset(fmt_offset), .half_prec(half_prec),
    .out_vld(out_vld), .out_smp(out_smp), .state(state)
);

// File: tb/sim_dcb_filter_top.sv
module sim_dcb_filter_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [11:0] in_smp = '0;
    logic        bypass = 1'b0;
    logic        fmt_offset = 1'b0;
    logic        half_prec = 1'b0;
    logic        out_vld;
    logic [11:0] out_smp;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rng = 32'h1234_5678;

    // behavioural reference state
    int xp_m = 0;
    int yf_m = 0;
    bit vq_m = 0;

    always #5 clk = ~clk;

    dcb_filter_top u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
        .bypass(bypass), .fmt_offset(fmt_offset), .half_prec(half_prec),
        .out_vld(out_vld), .out_smp(out_smp)
    );

    function automatic logic [31:0] nxt_rand();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    function automatic int to_int(logic [11:0] w);
        return int'($signed(w));
    endfunction

    function automatic logic [11:0] fmt_ref(int v, bit ob, bit hp);
        int s;
        logic [11:0] w;
        s = v;
        if (s > 2047)  s = 2047;
        if (s < -2048) s = -2048;
        w = s[11:0];
        if (hp) return {7'b0, w[11:7] ^ {ob, 4'b0}};
        return w ^ {ob, 11'b0};
    endfunction

    task automatic cyc(bit v, logic [11:0] x, bit b, bit f, bit h, bit r, string tag);
        bit ev;
        logic [11:0] ed;
        @(negedge clk);
        in_vld = v; in_smp = x; bypass = b; fmt_offset = f; half_prec = h; rst = r;
        #2;
        if (r)      begin ev = 0; ed = '0; end
        else if (b) begin ev = v; ed = fmt_ref(to_int(x), f, h); end
        else        begin ev = vq_m; ed = fmt_ref(yf_m >>> 6, f, h); end
        n_chk++;
        if (out_vld !== ev) begin
            n_bad++;
            $display("FAIL %s out_vld actual=%b expected=%b t=%0t", tag, out_vld, ev, $time);
        end
        if (ev) begin
            n_chk++;
            if (out_smp !== ed) begin
                n_bad++;
                $display("FAIL %s out_smp actual=%h expected=%h t=%0t", tag, out_smp, ed, $time);
            end
        end
        @(posedge clk);
        if (r || b) begin
            xp_m = 0; yf_m = 0; vq_m = 0;
        end else begin
            vq_m = v;
            if (v) begin
                yf_m = (to_int(x) - xp_m) * 64 + yf_m - (yf_m >>> 6);
                xp_m = to_int(x);
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        bit b;
        // R1: reset holds output quiet
        for (int i = 0; i < 4; i++) cyc(1, 12'h3A5, 0, 0, 0, 1, "R1");
        // R2: zero-latency bypass, all formats
        for (int i = 0; i < 200; i++) begin
            r = nxt_rand();
            cyc(r[0] | r[1], r[27:16], 1, r[2], r[3], 0, "R2");
        end
        // R3/R4: filter with gaps, full precision two's complement
        for (int i = 0; i < 400; i++) begin
            r = nxt_rand();
            cyc(r[0] | r[1], r[27:16], 0, 0, 0, 0, "R3");
        end
        // R6/R7: filter with format and precision changes
        for (int i = 0; i < 300; i++) begin
            r = nxt_rand();
            cyc(r[0] | r[1], r[27:16], 0, r[2], r[3], 0, "R7");
        end
        // R8: bypass toggling clears history
        b = 0;
        for (int i = 0; i < 500; i++) begin
            r = nxt_rand();
            if (r[7:4] == 0) b = ~b;
            cyc(r[0] | r[1], r[27:16], b, r[2], r[3], 0, "R8");
        end
        // R8: first sample after release equals itself
        cyc(1, 12'h123, 1, 0, 0, 0, "R8");
        cyc(1, 12'h456, 0, 0, 0, 0, "R8");
        cyc(0, 12'h000, 0, 0, 0, 0, "R8");
        // R5: full-scale steps saturate, never wrap
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 300; i++) cyc(1, 12'h800, 0, 0, 0, 0, "R5");
            for (int i = 0; i < 4; i++)   cyc(1, 12'h7FF, 0, 0, 0, 0, "R5");
            for (int i = 0; i < 300; i++) cyc(1, 12'h7FF, 0, k[0], 0, 0, "R5");
            for (int i = 0; i < 4; i++)   cyc(1, 12'h800, 0, 0, 0, 0, "R5");
        end
        // R6: offset binary of midscale in both precisions
        cyc(1, 12'h000, 1, 1, 0, 0, "R6");
        cyc(1, 12'h000, 1, 1, 1, 0, "R6");
        // R9: constant input decays to zero
        for (int i = 0; i < 1500; i++) cyc(1, 12'd1000, 0, 0, 0, 0, "R9");
        @(negedge clk);
        #2;
        n_chk++;
        if (out_vld !== 1'b1 || out_smp !== 12'h000) begin
            n_bad++;
            $display("FAIL R9 settled actual=%b/%h expected=1/000", out_vld, out_smp);
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule